// File: doc/BRIEF.md
# Index/Data Global Configuration Register File

This block holds the chip-wide configuration registers that a host reaches through a pair of ports. The host first writes an 8-bit register number to the index port. It then reads or writes the chosen register through the data port. The registers can be reached only while the configuration-mode input is high. Outside that mode the data port reads back zero and its writes are dropped.

Three locations are implemented. The first is a control register whose bit 0 fires a soft reset and then clears itself. The second is a run-mode control register that carries an access-enable flag and a 2-bit selector, which picks one of four run-mode port addresses. The third holds the number of the current logical device. The block drives the soft-reset pulse, the run-mode access enable, the decoded run-mode port address and the logical device number to the rest of the chip. Every other register number reads as zero and ignores writes.

Top module: `glb_cfg_regfile`

## Requirements
- R1: After rst_n is released, the index reads 0x00, location 0x03 reads 0x03, location 0x07 reads 0x00, run_acc_en is 0, run_port_addr is 0xEA and soft_rst_pulse is 0.
- R2: All 8 bits of the index are decoded. Only 0x02, 0x03 and 0x07 are implemented. Every other index value reads 0x00 on dat_rdata, and a data write to it leaves all outputs and all implemented registers unchanged.
- R3: While cfg_mode is 0, dat_rdata is 0x00, and data writes and index writes have no effect on any register or output.
- R4: A data write in configuration mode to 0x02 with bit 0 set makes soft_rst_pulse high for exactly the one cycle after the capturing clock edge. A write to 0x02 with bit 0 clear makes no pulse. Location 0x02 always reads 0x00.
- R5: A soft reset returns location 0x03 to 0x03 and location 0x07 to 0x00 at the capturing edge. It leaves the index register unchanged.
- R6: Bits [1:0] of location 0x03 select run_port_addr: 00 gives 0xE0, 01 gives 0xE2, 10 gives 0xE4 and 11 gives 0xEA.
- R7: Bit 7 of location 0x03 drives run_acc_en from the cycle after the write. Bits [6:2] of location 0x03 ignore writes and read as 0.
- R8: Location 0x07 stores all 8 written bits, reads them back and drives them on ldev_num from the cycle after the write.
- R9: While rst_n is low, a data write that would trigger a soft reset produces no pulse. The hardware reset values apply instead.
- R10: idx_rdata shows the index register, which takes the value on wdata at the clock edge where idx_we and cfg_mode are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| cfg_mode | input | 1 | Configuration mode is active |
| idx_we | input | 1 | Index port write strobe |
| dat_we | input | 1 | Data port write strobe |
| wdata | input | 8 | Write data shared by both ports |
| idx_rdata | output | 8 | Current index value |
| dat_rdata | output | 8 | Contents of the register selected by the index |
| soft_rst_pulse | output | 1 | One-cycle soft-reset pulse |
| run_acc_en | output | 1 | Run-mode register access enable |
| run_port_addr | output | 8 | Selected run-mode port address |
| ldev_num | output | 8 | Current logical device number |

## Verification
On every cycle the assertions check four things. The data port is silent outside configuration mode. The soft-reset pulse never lasts two cycles. A soft reset leaves the registers at their default values. Writes to 0x03 and 0x07 land on the outputs one cycle later. Other properties need the bench's scenarios, because they depend on a sweep over data and on read-back through the data port. These are the full 8-bit decode across all 256 index values, the four-way port-address mapping, the reserved bits reading zero, the index staying put across a soft reset, and hardware reset overriding a soft-reset write.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

   localparam int NUM_REGS = 3;

   typedef enum logic [1:0] {
      SEL_SRST = 2'd0,
      SEL_PSEL = 2'd1,
      SEL_LDEV = 2'd2
   } reg_id_e;

   localparam logic [7:0] LOC_SRST = 8'h02;
   localparam logic [7:0] LOC_PSEL = 8'h03;
   localparam logic [7:0] LOC_LDEV = 8'h07;

   function automatic logic [7:0] reg_loc(input int k);
      case (k)
         0:       reg_loc = LOC_SRST;
         1:       reg_loc = LOC_PSEL;
         default: reg_loc = LOC_LDEV;
      endcase
   endfunction

endpackage

// File: rtl/cfg_index_reg.sv
module cfg_index_reg #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_mode,
   input  logic             idx_we,
   input  logic [IDX_W-1:0] wdata,
   output logic [IDX_W-1:0] idx_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_q <= '0;
      else if (cfg_mode && idx_we)
         idx_q <= wdata;
   end

endmodule

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
   import cfgreg_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic [IDX_W-1:0]    idx,
   output logic [NUM_REGS-1:0] hit
);

   // one comparator per implemented location, full index width
   for (genvar k = 0; k < NUM_REGS; k++) begin : g_cmp
      localparam logic [IDX_W-1:0] LOC = IDX_W'(reg_loc(k));
      assign hit[k] = (idx == LOC);
   end

endmodule

// File: rtl/cfg_ctrl_regs.sv
module cfg_ctrl_regs
   import cfgreg_pkg::*;
#(
   parameter int         DATA_W   = 8,
   parameter int         LDEV_W   = 8,
   parameter logic [1:0] PSEL_RST = 2'b11,
   parameter logic       ACC_RST  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [NUM_REGS-1:0] hit,
   input  logic [DATA_W-1:0]   wdata,
   output logic                acc_en_q,
   output logic [1:0]          psel_q,
   output logic [LDEV_W-1:0]   ldev_q,
   output logic                srst_q
);

   logic fire_srst;
   logic wr_psel;
   logic wr_ldev;

   assign fire_srst = wr_en && hit[SEL_SRST] && wdata[0];
   assign wr_psel   = wr_en && hit[SEL_PSEL];
   assign wr_ldev   = wr_en && hit[SEL_LDEV];

   // hardware reset outranks the soft reset
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_en_q <= ACC_RST;
         psel_q   <= PSEL_RST;
         ldev_q   <= '0;
         srst_q   <= 1'b0;
      end else begin
         srst_q <= fire_srst;
         if (fire_srst) begin
            acc_en_q <= ACC_RST;
            psel_q   <= PSEL_RST;
            ldev_q   <= '0;
         end else begin
            if (wr_psel) begin
               acc_en_q <= wdata[7];
               psel_q   <= wdata[1:0];
            end
            if (wr_ldev)
               ldev_q <= wdata[LDEV_W-1:0];
         end
      end
   end

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
   import cfgreg_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LDEV_W = 8
) (
   input  logic                cfg_mode,
   input  logic [NUM_REGS-1:0] hit,
   input  logic                acc_en_q,
   input  logic [1:0]          psel_q,
   input  logic [LDEV_W-1:0]   ldev_q,
   output logic [DATA_W-1:0]   rdata
);

   logic [DATA_W-1:0] ldev_ext;

   if (LDEV_W < DATA_W) begin : g_pad
      assign ldev_ext = {{(DATA_W-LDEV_W){1'b0}}, ldev_q};
   end else begin : g_full
      assign ldev_ext = ldev_q;
   end

   always_comb begin
      rdata = '0;
      if (cfg_mode) begin
         if (hit[SEL_PSEL]) begin
            rdata[7]   = acc_en_q;
            rdata[1:0] = psel_q;
         end
         if (hit[SEL_LDEV])
            rdata = ldev_ext;
      end
   end

endmodule

// File: rtl/glb_cfg_regfile.sv
module glb_cfg_regfile
   import cfgreg_pkg::*;
#(
   parameter int              IDX_W    = 8,
   parameter int              DATA_W   = 8,
   parameter int              LDEV_W   = 8,
   parameter logic [1:0]      PSEL_RST = 2'b11,
   parameter logic            ACC_RST  = 1'b0,
   parameter logic [3:0][7:0] PORT_TBL = {8'hEA, 8'hE4, 8'hE2, 8'hE0}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mode,
   input  logic              idx_we,
   input  logic              dat_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [IDX_W-1:0]  idx_rdata,
   output logic [DATA_W-1:0] dat_rdata,
   output logic              soft_rst_pulse,
   output logic              run_acc_en,
   output logic [7:0]        run_port_addr,
   output logic [LDEV_W-1:0] ldev_num
);

   if (IDX_W != 8) begin : g_bad_idx
      $error("IDX_W must be 8 so that all index bits are decoded");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("DATA_W must be 8");
   end
   if (LDEV_W < 1 || LDEV_W > DATA_W) begin : g_bad_ldev
      $error("LDEV_W must lie in 1..DATA_W");
   end

   logic [NUM_REGS-1:0] hit;
   logic                acc_en_q;
   logic [1:0]          psel_q;
   logic [LDEV_W-1:0]   ldev_q;
   logic                srst_q;
   logic                wr_en;

   assign wr_en = cfg_mode && dat_we;

   cfg_index_reg #(.IDX_W(IDX_W)) u_idx (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_mode (cfg_mode),
      .idx_we   (idx_we),
      .wdata    (wdata),
      .idx_q    (idx_rdata)
   );

   cfg_addr_decode #(.IDX_W(IDX_W)) u_dec (
      .idx (idx_rdata),
      .hit (hit)
   );

   cfg_ctrl_regs #(
      .DATA_W   (DATA_W),
      .LDEV_W   (LDEV_W),
      .PSEL_RST (PSEL_RST),
      .ACC_RST  (ACC_RST)
   ) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .hit      (hit),
      .wdata    (wdata),
      .acc_en_q (acc_en_q),
      .psel_q   (psel_q),
      .ldev_q   (ldev_q),
      .srst_q   (srst_q)
   );

   cfg_read_mux #(.DATA_W(DATA_W), .LDEV_W(LDEV_W)) u_rd (
      .cfg_mode (cfg_mode),
      .hit      (hit),
      .acc_en_q (acc_en_q),
      .psel_q   (psel_q),
      .ldev_q   (ldev_q),
      .rdata    (dat_rdata)
   );

   assign soft_rst_pulse = srst_q;
   assign run_acc_en     = acc_en_q;
   assign run_port_addr  = PORT_TBL[psel_q];
   assign ldev_num       = ldev_q;

endmodule

// File: rtl/glb_cfg_regfile_chk.sv
module glb_cfg_regfile_chk #(
   parameter int IDX_W  = 8,
   parameter int DATA_W = 8,
   parameter int LDEV_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_mode,
   input logic              dat_we,
   input logic [DATA_W-1:0] wdata,
   input logic [IDX_W-1:0]  idx_rdata,
   input logic [DATA_W-1:0] dat_rdata,
   input logic              soft_rst_pulse,
   input logic              run_acc_en,
   input logic [7:0]        run_port_addr,
   input logic [LDEV_W-1:0] ldev_num
);

   // R3
   rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mode |-> dat_rdata == '0);

   // R3
   wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_mode && dat_we) |=> ($stable(ldev_num) && $stable(run_acc_en)
                                 && !soft_rst_pulse));

   // R4
   pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_pulse |=> !soft_rst_pulse);

   // R5
   srst_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_pulse |-> (ldev_num == '0 && !run_acc_en && run_port_addr == 8'hEA));

   // R7
   acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode && dat_we && idx_rdata == 8'h03) |=> run_acc_en == $past(wdata[7]));

   // R8
   ldev_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode && dat_we && idx_rdata == 8'h07) |=> ldev_num == $past(wdata[LDEV_W-1:0]));

endmodule

bind glb_cfg_regfile glb_cfg_regfile_chk #(
   .IDX_W  (IDX_W),
   .DATA_W (DATA_W),
   .LDEV_W (LDEV_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_mode       (cfg_mode),
   .dat_we         (dat_we),
   .wdata          (wdata),
   .idx_rdata      (idx_rdata),
   .dat_rdata      (dat_rdata),
   .soft_rst_pulse (soft_rst_pulse),
   .run_acc_en     (run_acc_en),
   .run_port_addr  (run_port_addr),
   .ldev_num       (ldev_num)
);

// File: tb/sim_glb_cfg_regfile.sv
`timescale 1ns/1ps
module sim_glb_cfg_regfile;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_mode = 1'b0;
   logic       idx_we = 1'b0;
   logic       dat_we = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] idx_rdata;
   logic [7:0] dat_rdata;
   logic       soft_rst_pulse;
   logic       run_acc_en;
   logic [7:0] run_port_addr;
   logic [7:0] ldev_num;

   int total = 0;
   int bad = 0;

   // bench model of the register state
   logic       m_acc = 1'b0;
   logic [1:0] m_psel = 2'b11;
   logic [7:0] m_ldev = 8'h00;
   logic [7:0] m_idx = 8'h00;

   always #10 clk = ~clk;

   glb_cfg_regfile u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_mode       (cfg_mode),
      .idx_we         (idx_we),
      .dat_we         (dat_we),
      .wdata          (wdata),
      .idx_rdata      (idx_rdata),
      .dat_rdata      (dat_rdata),
      .soft_rst_pulse (soft_rst_pulse),
      .run_acc_en     (run_acc_en),
      .run_port_addr  (run_port_addr),
      .ldev_num       (ldev_num)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] port_of(input logic [1:0] s);
      case (s)
         2'b00:   port_of = 8'hE0;
         2'b01:   port_of = 8'hE2;
         2'b10:   port_of = 8'hE4;
         default: port_of = 8'hEA;
      endcase
   endfunction

   function automatic logic [7:0] model_rd(input logic [7:0] i);
      if (i == 8'h03)      model_rd = {m_acc, 5'b00000, m_psel};
      else if (i == 8'h07) model_rd = m_ldev;
      else                 model_rd = 8'h00;
   endfunction

   task automatic check_outs(input string req);
      chk({req, " acc"}, {7'b0, run_acc_en}, {7'b0, m_acc});
      chk({req, " port"}, run_port_addr, port_of(m_psel));
      chk({req, " ldev"}, ldev_num, m_ldev);
   endtask

   task automatic wr_idx(input logic [7:0] v);
      @(negedge clk);
      idx_we = 1'b1;
      wdata  = v;
      @(negedge clk);
      idx_we = 1'b0;
      if (cfg_mode) m_idx = v;
   endtask

   task automatic wr_dat(input logic [7:0] v, input string req);
      logic fire;
      fire = cfg_mode && (m_idx == 8'h02) && v[0];
      @(negedge clk);
      dat_we = 1'b1;
      wdata  = v;
      @(posedge clk);
      #1;
      chk({req, " pulse"}, {7'b0, soft_rst_pulse}, {7'b0, fire});
      if (cfg_mode) begin
         if (fire) begin
            m_acc = 1'b0; m_psel = 2'b11; m_ldev = 8'h00;
         end else if (m_idx == 8'h03) begin
            m_acc = v[7]; m_psel = v[1:0];
         end else if (m_idx == 8'h07) begin
            m_ldev = v;
         end
      end
      @(negedge clk);
      dat_we = 1'b0;
      @(posedge clk);
      #1;
      chk({req, " pulse end"}, {7'b0, soft_rst_pulse}, 8'h00);
   endtask

   initial begin
      #(20 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 idx", idx_rdata, 8'h00);
      chk("R1 pulse", {7'b0, soft_rst_pulse}, 8'h00);
      check_outs("R1");
      cfg_mode = 1'b1;
      wr_idx(8'h03);
      chk("R1 loc3", dat_rdata, 8'h03);
      wr_idx(8'h07);
      chk("R1 loc7", dat_rdata, 8'h00);

      // R3 outside configuration mode
      wr_idx(8'h07);
      wr_dat(8'h3C, "R8 setup");
      cfg_mode = 1'b0;
      #1;
      chk("R3 rd zero", dat_rdata, 8'h00);
      wr_dat(8'hC3, "R3 wr");
      wr_idx(8'h03);
      chk("R3 idx hold", idx_rdata, 8'h07);
      check_outs("R3");
      cfg_mode = 1'b1;
      #1;
      chk("R3 ldev kept", dat_rdata, 8'h3C);

      // R2 R10 sweep over all index values
      for (int i = 0; i < 256; i++) begin
         logic [7:0] p;
         p = 8'(i) ^ 8'hA5;
         wr_idx(8'(i));
         chk("R10 idx", idx_rdata, 8'(i));
         wr_dat(p, "R2 sweep");
         #1;
         chk("R2 read", dat_rdata, model_rd(8'(i)));
         check_outs("R2");
         chk("R5 idx kept", idx_rdata, 8'(i));
      end

      // R6 R7 selector and enable combinations
      wr_idx(8'h03);
      for (int s = 0; s < 8; s++) begin
         logic [7:0] v;
         v = {s[2], 5'b11111, s[1:0]};
         wr_dat(v, "R6 sel");
         check_outs("R6");
         chk("R7 rsvd", dat_rdata, {s[2], 5'b00000, s[1:0]});
      end

      // R4 R5 soft reset from non-default state
      wr_idx(8'h07);
      wr_dat(8'h5C, "R8 ldev");
      chk("R8 read", dat_rdata, 8'h5C);
      wr_idx(8'h03);
      wr_dat(8'h81, "R7 set");
      wr_idx(8'h02);
      wr_dat(8'hFE, "R4 bit0 clear");
      check_outs("R4 no effect");
      chk("R4 read0", dat_rdata, 8'h00);
      wr_dat(8'h01, "R4 fire");
      check_outs("R5");
      chk("R5 idx", idx_rdata, 8'h02);
      chk("R4 read0 after", dat_rdata, 8'h00);

      // R9 hardware reset outranks soft reset
      wr_idx(8'h03);
      wr_dat(8'h80, "R9 setup");
      wr_idx(8'h02);
      @(negedge clk);
      rst_n  = 1'b0;
      dat_we = 1'b1;
      wdata  = 8'h01;
      @(posedge clk);
      #1;
      chk("R9 pulse", {7'b0, soft_rst_pulse}, 8'h00);
      m_acc = 1'b0; m_psel = 2'b11; m_ldev = 8'h00; m_idx = 8'h00;
      check_outs("R9");
      chk("R9 idx", idx_rdata, 8'h00);
      @(negedge clk);
      dat_we = 1'b0;
      rst_n  = 1'b1;
      @(posedge clk);
      #1;
      chk("R9 pulse after", {7'b0, soft_rst_pulse}, 8'h00);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule